// File: doc/BRIEF.md
# Polled Byte-Wide SPI Master

This peripheral drives a four-wire SPI bus as bus master. A host reaches it through a plain 32-bit register port: a write strobe, a read strobe, a byte address, write data, and combinational read data. The host sets the serial clock rate and the clock mode in a control register and drives the chip-select line by software through a select register. It then writes one byte to the transmit register. That write starts a full-duplex exchange of eight bits, most significant bit first, and the byte shifted in from the slave lands in a receive register.

The host learns about progress only by polling the status register. A busy flag stays set while the exchange runs. A sticky receive-ready flag goes up when the received byte can be read. Reading the receive register drops the ready flag, and so does any write to the status register. The serial clock rate comes from two stages: a selectable fixed prescale of 16 or 128, then a programmable divide by twice a 5-bit field plus two. Rate and mode are captured when a transfer starts, so later writes to the control register only affect the next transfer.

Top module: `regspi_master`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (status), 0x08 (select), 0x0C (transmit, write only), 0x10 (receive, low 8 bits). Control and select read back the full word last written. The transmit offset and every unused offset, 0x14 included, read as zero.
- R2: With control bit 5 clear the prescale P is 16, and with it set P is 128. With N taken from control bits 4:0, every serial clock half period lasts P*(N+1) clock cycles. Status bit 0 reads 1 from the cycle after the transmit write until 16 half periods have passed.
- R3: The chip-select output follows bit 6 of the select register from the cycle after a write (0 drives it low, 1 drives it high). The select register resets to 0x40.
- R4: When no transfer is running, the serial clock sits at control bit 6. During a transfer it starts at the polarity latched at the start and toggles once per half period, 16 times in all.
- R5: With control bit 7 (phase) clear, input is sampled on the odd clock edges and output changes on the even edges. With it set, output changes on odd edges from the third onward and input is sampled on the even edges.
- R6: Data leaves MSB first. Bit 7 of the written byte appears on the output in the cycle after the transmit write. After a transfer the output holds the byte's bit 0.
- R7: When a transfer ends, the received byte is placed in the receive register and status bit 2 is set. A read of offset 0x10 clears bit 2, and so does any write to offset 0x04.
- R8: A transmit write made while status bit 0 is 1 is ignored: the running transfer, its output bits and its timing are unchanged, and no second transfer follows.
- R9: A control write during a transfer leaves that transfer's rate and mode unchanged. The new settings apply from the next transfer.
- R10: After reset, control and status read as zero, the serial clock and data output are low, and chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects) |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| csN | output | 1 | Chip select, software driven |

## Verification
The properties assume the host never issues a read and a write in the same cycle. They also assume the host never reads the receive register in the very cycle a transfer completes, because the flag-set priority there is left unconstrained. The stimulus is built to respect both. It moves strictly one operation per cycle, leaves each strobe high for exactly one clock, and waits for the ready flag by polling status, which has no side effects, before it reads the received byte. The slave data line changes only on the falling system clock edge, so it is stable whenever the design samples it, in either phase.

// File: rtl/regspi_pkg.sv
package regspi_pkg;
  localparam int WORD_W = 8;
  localparam int EDGES  = 2 * WORD_W;
  localparam int EDGE_W = $clog2(EDGES);

  // register byte offsets
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_SEL  = 'h08;
  localparam int OFF_TX   = 'h0C;
  localparam int OFF_RX   = 'h10;

  // bit positions
  localparam int CB_CPHA  = 7;
  localparam int CB_CPOL  = 6;
  localparam int CB_PSEL  = 5;
  localparam int SB_BUSY  = 0;
  localparam int SB_RXRDY = 2;
  localparam int SEL_CS   = 6;

  typedef struct packed {
    logic load;    // start: capture transmit byte
    logic shift;   // move next bit onto the data output
    logic sample;  // take one bit from the data input
    logic finish;  // last edge: move received byte to buffer
  } spiStb_t;
endpackage

// File: rtl/regspi_ctl.sv
module regspi_ctl
  import regspi_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [WORD_W-1:0] rxByte,
  output spiStb_t           stb,
  output logic              xferBusy,
  output logic              sclk,
  output logic              csN
);
  localparam int CNT_W = $clog2(PRE_HI << DIV_W);
  localparam logic [DATA_W-1:0] SEL_RESET = DATA_W'(1) << SEL_CS;

  logic [DATA_W-1:0] ctrlReg, selReg;
  logic              busy, rxReady, xCpol, xCpha;
  logic [CNT_W-1:0]  divCnt, halfLim, nextLim;
  logic [EDGE_W-1:0] edgeCnt;
  logic wrCtrl, wrStat, wrSel, wrTx, rdRx;
  logic start, tick, lastEdge, oddEdge;

  always_comb begin
    wrCtrl   = regWrEn && (regAddr == ADDR_W'(OFF_CTRL));
    wrStat   = regWrEn && (regAddr == ADDR_W'(OFF_STAT));
    wrSel    = regWrEn && (regAddr == ADDR_W'(OFF_SEL));
    wrTx     = regWrEn && (regAddr == ADDR_W'(OFF_TX));
    rdRx     = regRdEn && (regAddr == ADDR_W'(OFF_RX));
    start    = wrTx && !busy;
    tick     = busy && (divCnt == halfLim);
    lastEdge = tick && (edgeCnt == EDGE_W'(EDGES - 1));
    oddEdge  = !edgeCnt[0];
    nextLim  = CNT_W'((ctrlReg[CB_PSEL] ? PRE_HI : PRE_LO)
                      * (int'(ctrlReg[DIV_W-1:0]) + 1) - 1);
    stb.load   = start;
    stb.sample = tick && (xCpha ? !oddEdge : oddEdge);
    stb.shift  = tick && (xCpha ? (oddEdge && (edgeCnt != '0))
                                : (!oddEdge && !lastEdge));
    stb.finish = lastEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      selReg  <= SEL_RESET;
      busy    <= 1'b0;
      rxReady <= 1'b0;
      xCpol   <= 1'b0;
      xCpha   <= 1'b0;
      divCnt  <= '0;
      halfLim <= '0;
      edgeCnt <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= regWrData;
      if (wrSel)  selReg  <= regWrData;
      if (lastEdge)             rxReady <= 1'b1;
      else if (wrStat || rdRx)  rxReady <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        divCnt  <= '0;
        edgeCnt <= '0;
        halfLim <= nextLim;
        xCpol   <= ctrlReg[CB_CPOL];
        xCpha   <= ctrlReg[CB_CPHA];
      end else if (busy) begin
        if (tick) begin
          divCnt  <= '0;
          edgeCnt <= edgeCnt + 1'b1;
          if (lastEdge) busy <= 1'b0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(OFF_CTRL): regRdData = ctrlReg;
      ADDR_W'(OFF_STAT): begin
        regRdData[SB_BUSY]  = busy;
        regRdData[SB_RXRDY] = rxReady;
      end
      ADDR_W'(OFF_SEL):  regRdData = selReg;
      ADDR_W'(OFF_RX):   regRdData[WORD_W-1:0] = rxByte;
      default:           regRdData = '0;
    endcase
  end

  assign xferBusy = busy;
  assign sclk     = busy ? (xCpol ^ edgeCnt[0]) : ctrlReg[CB_CPOL];
  assign csN      = selReg[SEL_CS];
endmodule

// File: rtl/regspi_dp.sv
module regspi_dp
  import regspi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spiStb_t           stb,
  input  logic [WORD_W-1:0] txData,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxByte
);
  logic [WORD_W-1:0] txShift, rxShift, rxBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxBuf   <= '0;
    end else begin
      if (stb.load)       txShift <= txData;
      else if (stb.shift) txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (stb.sample)     rxShift <= {rxShift[WORD_W-2:0], miso};
      if (stb.finish)
        rxBuf <= stb.sample ? {rxShift[WORD_W-2:0], miso} : rxShift;
    end
  end

  assign mosi   = txShift[WORD_W-1];
  assign rxByte = rxBuf;
endmodule

// File: rtl/regspi_master.sv
module regspi_master
  import regspi_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  spiStb_t           stb;
  logic              xferBusy;
  logic [WORD_W-1:0] rxByte;

  regspi_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LO(PRE_LO),
    .PRE_HI(PRE_HI), .DIV_W(DIV_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rxByte(rxByte), .stb(stb), .xferBusy(xferBusy), .sclk(sclk), .csN(csN)
  );

  regspi_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(regWrData[WORD_W-1:0]),
    .miso(miso), .mosi(mosi), .rxByte(rxByte)
  );
endmodule

// File: rtl/regspi_master_chk.sv
module regspi_master_chk
  import regspi_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrMsb,
  input logic              wrCs,
  input logic              sclk,
  input logic              mosi,
  input logic              csN,
  input logic              xferBusy,
  input spiStb_t           stb
);
  a_r3_cs_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFF_SEL)) |=> (csN == $past(wrCs)));

  a_r4_sclk_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!xferBusy && !$past(xferBusy) && !$past(regWrEn)) |-> $stable(sclk));

  a_r5_one_action_per_edge: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.shift, stb.sample}));

  a_r6_mosi_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.shift && !stb.load) |=> $stable(mosi));

  a_r6_msb_on_start: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (xferBusy && mosi == $past(wrMsb)));
endmodule

bind regspi_master regspi_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .wrMsb(regWrData[regspi_pkg::WORD_W-1]), .wrCs(regWrData[regspi_pkg::SEL_CS]),
  .sclk(sclk), .mosi(mosi), .csN(csN), .xferBusy(xferBusy), .stb(stb)
);

// File: tb/sim_regspi_master.sv
module sim_regspi_master;
  logic        clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, regRdEn = 1'b0, miso = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, lastRd;
  logic        sclk, mosi, csN;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  regspi_master u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  // behavioural reference state
  logic [31:0] mCtrl, mSs;
  logic        mBusy, mRxRdy, mCpol, mCpha, mLastMosi;
  logic [7:0]  mTx, mSlave, mRxBuf, slaveNext = 8'h00;
  int          mCyc, mHalf;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mSs = 32'h40; mBusy = 0; mRxRdy = 0; mCpol = 0; mCpha = 0;
      mLastMosi = 0; mTx = 0; mSlave = 0; mRxBuf = 0; mCyc = 0; mHalf = 16;
    end else begin
      if ((regWrEn && regAddr == 5'h04) || (regRdEn && regAddr == 5'h10)) mRxRdy = 0;
      if (mBusy) begin
        mCyc++;
        if (mCyc == 16 * mHalf) begin
          mBusy = 0; mRxRdy = 1; mRxBuf = mSlave; mLastMosi = mTx[0];
        end
      end else if (regWrEn && regAddr == 5'h0C) begin
        mBusy = 1; mCyc = 0; mTx = regWrData[7:0]; mSlave = slaveNext;
        mCpol = mCtrl[6]; mCpha = mCtrl[7];
        mHalf = (mCtrl[5] ? 128 : 16) * (int'(mCtrl[4:0]) + 1);
      end
      if (regWrEn && regAddr == 5'h00) mCtrl = regWrData;
      if (regWrEn && regAddr == 5'h08) mSs = regWrData;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [4:0] a);
    case (a)
      5'h00: return mCtrl;
      5'h04: return {29'b0, mRxRdy, 1'b0, mBusy};
      5'h08: return mSs;
      5'h10: return {24'b0, mRxBuf};
      default: return 32'h0;
    endcase
  endfunction

  // per-cycle comparison of the serial pins, slave drive on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      int t, idx, s;
      logic eS, eM;
      if (mBusy) begin
        t   = mCyc / mHalf;
        eS  = mCpol ^ t[0];
        idx = mCpha ? ((t == 0) ? 7 : 7 - (t - 1) / 2) : 7 - t / 2;
        eM  = mTx[idx];
        s   = mCpha ? t / 2 : (t + 1) / 2;
        miso = (s < 8) ? mSlave[7 - s] : 1'b0;
      end else begin
        eS = mCtrl[6]; eM = mLastMosi; miso = 1'b0;
      end
      check("R4/R2", "sclk", {31'b0, sclk}, {31'b0, eS});
      check("R6/R5", "mosi", {31'b0, mosi}, {31'b0, eM});
      check("R3", "csN", {31'b0, csN}, {31'b0, mSs[6]});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input string req);
    regAddr = a; regRdEn = 1'b1;
    #1;
    lastRd = regRdData;
    check(req, "read", regRdData, expRead(a));
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitReady(input string req);
    for (int i = 0; i < 20000; i++) begin
      rd(5'h04, req);
      if (lastRd[2]) break;
    end
  endtask

  task automatic xfer(input logic [31:0] ctrl, input logic [7:0] tx, input logic [7:0] sl);
    wr(5'h00, ctrl);
    slaveNext = sl;
    wr(5'h0C, {24'b0, tx});
    waitReady("R2");
    rd(5'h10, "R7");
    check("R7", "rx byte", {24'b0, lastRd[7:0]}, {24'b0, sl});
    rd(5'h04, "R7");
    check("R7", "ready cleared by rx read", {31'b0, lastRd[2]}, 32'h0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "sclk reset", {31'b0, sclk}, 32'h0);
    check("R10", "mosi reset", {31'b0, mosi}, 32'h0);
    check("R10", "csN reset", {31'b0, csN}, 32'h1);
    rd(5'h00, "R10");
    rd(5'h04, "R10");
    rd(5'h08, "R10");
    // R1 / R3 register access and chip select
    wr(5'h08, 32'h21);
    rd(5'h08, "R1");
    check("R3", "csN asserted", {31'b0, csN}, 32'h0);
    rd(5'h14, "R1");
    rd(5'h0C, "R1");
    wr(5'h00, 32'hDEAD_BE00);
    rd(5'h00, "R1");
    // R5 / R6 all four modes, R2 rates
    xfer(32'h00, 8'hA5, 8'h3C);
    xfer(32'h81, 8'h5A, 8'hC3);
    xfer(32'h42, 8'h96, 8'h69);
    xfer(32'hC0, 8'h01, 8'h80);
    xfer(32'h20, 8'hF0, 8'h0F);
    // R8 transmit write while busy is ignored
    wr(5'h00, 32'h00);
    slaveNext = 8'h55;
    wr(5'h0C, 32'h33);
    repeat (40) @(negedge clk);
    slaveNext = 8'hEE;
    wr(5'h0C, 32'hFF);
    waitReady("R8");
    rd(5'h10, "R8");
    check("R8", "rx of first transfer", {24'b0, lastRd[7:0]}, 32'h55);
    repeat (20) @(negedge clk);
    rd(5'h04, "R8");
    check("R8", "no second transfer", {31'b0, lastRd[0]}, 32'h0);
    // R9 control change during transfer
    slaveNext = 8'hB2;
    wr(5'h0C, 32'h4D);
    repeat (30) @(negedge clk);
    wr(5'h00, 32'hC1);
    waitReady("R9");
    rd(5'h10, "R9");
    check("R9", "rx with old mode", {24'b0, lastRd[7:0]}, 32'hB2);
    xfer(32'hC1, 8'h77, 8'h1E);
    // R7 status write clears ready flag
    slaveNext = 8'h99;
    wr(5'h0C, 32'h24);
    waitReady("R7");
    wr(5'h04, 32'h0);
    rd(5'h04, "R7");
    check("R7", "ready cleared by status write", {31'b0, lastRd[2]}, 32'h0);
    rd(5'h10, "R7");
    // R3 deassert
    wr(5'h08, 32'h40);
    check("R3", "csN deasserted", {31'b0, csN}, 32'h1);
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule